// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is a bus slave that gives a controller access to an internal byte-wide register file over a three-wire serial link. The link consists of a serial clock, an active-low select and one shared data line. The pad is outside the block, so the shared line is presented as separate input, output and output-enable pins. The serial inputs are brought into the system clock domain by synchronizer chains. Edges of the serial clock are then detected in that domain.

Every access is a pair of bytes framed by one low pulse of select. The first byte is an instruction and the second byte is an address or a data byte. The block keeps an 8-bit address pointer. The instruction can load the pointer, write the register at the pointer, or read it back onto the shared line. Some instructions also step the pointer afterwards. One bit of a configuration register chooses whether read data is driven push-pull or open-drain.

Top module: `tw_reg_slave`

## Requirements
- R1: While select is high, the block is idle and does not drive the line. Within four system clocks after select rises, `sdata_oe_o` is 0. Raising select discards any partly received pair.
- R2: Instruction 0x00 loads the second byte into the address pointer. No register is written and the line is not driven.
- R3: Instruction 0x40 stores the second byte in the register at the pointer. The pointer is left unchanged.
- R4: Instruction 0x60 stores the second byte at the pointer and then adds one to the pointer.
- R5: Instruction 0x80 returns the register at the pointer during the second byte, most significant bit first. Bits are captured on rising serial clock edges. Each returned bit is changed on a falling serial clock edge, and the first one appears on the first falling edge of the second byte. The line is not driven during the first byte.
- R6: Instruction 0xA0 returns the register at the pointer as in R5 and then adds one to the pointer.
- R7: The pointer wraps from 0xFF to 0x00 when it is incremented.
- R8: Any other instruction byte causes the second byte to be ignored. No register is written, the pointer does not change and the line is not driven.
- R9: Bit 4 of register 2 selects the drive mode: 1 means open-drain and 0 means push-pull. In open-drain mode, `sdata_oe_o` is high only for 0 bits, and `sdata_o` is 0 whenever the output is enabled. In push-pull mode, `sdata_oe_o` is high for every returned bit and `sdata_o` carries the bit.
- R10: Addresses at or above NUM_REGS have no storage. Writes to them are dropped and reads from them return 0x00.
- R11: Serial clock edges while select is high have no effect. Within a frame, bits after the sixteenth are ignored.
- R12: After reset, every register, the pointer and the output enable are 0. The drive mode is therefore push-pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| sel_ni | input | 1 | Select, active low, frames one byte pair |
| sdata_i | input | 1 | Serial data as seen at the pad |
| sdata_o | output | 1 | Serial data driven toward the pad |
| sdata_oe_o | output | 1 | Pad output enable |

## Verification
The bench builds the block with NUM_REGS set to 16. With that setting, pointer values above the backed range are easy to reach. The bench uses them to check dropped writes, zero reads and the wrap from 0xFF through unbacked space to 0x00 in a few frames. SYNC_STAGES stays at 2. The serial half-period is six system clocks, which leaves margin over the path from the input synchronizers to the output register. The bench also enables open-drain mode by writing register 2. It then reads patterns that contain both 0 and 1 bits, so the output enable is seen toggling within a byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef struct packed {
    logic valid;
    logic seta;
    logic wr;
    logic rd;
    logic inc;
  } op_t;

  function automatic op_t decode_op(input logic [7:0] ins);
    op_t op;
    op = '0;
    case (ins)
      8'h00: begin op.valid = 1'b1; op.seta = 1'b1; end
      8'h40: begin op.valid = 1'b1; op.wr = 1'b1; end
      8'h60: begin op.valid = 1'b1; op.wr = 1'b1; op.inc = 1'b1; end
      8'h80: begin op.valid = 1'b1; op.rd = 1'b1; end
      8'hA0: begin op.valid = 1'b1; op.rd = 1'b1; op.inc = 1'b1; end
      default: op = '0;
    endcase
    return op;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int unsigned NUM_REGS = 256,
  parameter int unsigned MODE_REG = 2,
  parameter int unsigned MODE_BIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       od_mode_o
);
  localparam logic [8:0] LIMIT = 9'(NUM_REGS);

  logic [7:0] mem_q [NUM_REGS];
  logic       hit;

  assign hit = {1'b0, addr_i} < LIMIT;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[r] <= '0;
      else if (wr_en_i && hit && addr_i == 8'(r)) mem_q[r] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (hit && addr_i == 8'(r)) rd_data_o = mem_q[r];
  end

  if (NUM_REGS > MODE_REG) begin : g_mode
    assign od_mode_o = mem_q[MODE_REG][MODE_BIT];
  end else begin : g_no_mode
    assign od_mode_o = 1'b0;
  end
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sel_ni,
  input  logic       sd_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sdo_o,
  output logic       drive_o
);
  localparam int unsigned FRAME_BITS = 16;

  logic       sclk_d;
  logic       rise, fall;
  logic [4:0] bit_cnt;
  logic [7:0] sh_q, sh_next, rd_byte_q, ptr_q;
  op_t        op_q;
  logic       exec, drive_q, sdo_q;

  assign rise    = sclk_i & ~sclk_d & ~sel_ni;
  assign fall    = ~sclk_i & sclk_d & ~sel_ni;
  assign sh_next = {sh_q[6:0], sd_i};
  assign exec    = rise && bit_cnt == 5'(FRAME_BITS-1) && op_q.valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b1;
    else sclk_d <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      sh_q      <= '0;
      op_q      <= '0;
      rd_byte_q <= '0;
      drive_q   <= 1'b0;
      sdo_q     <= 1'b0;
    end else if (sel_ni) begin
      bit_cnt <= '0;
      op_q    <= '0;
      drive_q <= 1'b0;
    end else begin
      if (rise && bit_cnt < 5'(FRAME_BITS)) begin
        sh_q    <= sh_next;
        bit_cnt <= bit_cnt + 5'd1;
        if (bit_cnt == 5'd7) begin
          op_q      <= decode_op(sh_next);
          rd_byte_q <= rd_data_i;
        end
      end
      // second byte of a read: new bit on each falling edge
      if (fall && bit_cnt[4:3] == 2'b01 && op_q.rd) begin
        drive_q <= 1'b1;
        sdo_q   <= rd_byte_q[~bit_cnt[2:0]];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (exec && op_q.seta) ptr_q <= sh_next;
    else if (exec && op_q.inc) ptr_q <= ptr_q + 8'd1;
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = exec && op_q.wr;
  assign wr_data_o = sh_next;
  assign sdo_o     = sdo_q;
  assign drive_o   = drive_q;

  // R1
  sel_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> !drive_q);
  // R8
  drive_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> op_q.rd);
  // R7
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op_q.inc) |=> ptr_q == $past(ptr_q) + 8'd1);
  // R11
  bit_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 5'(FRAME_BITS));
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int unsigned NUM_REGS = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sel_ni,
  input  logic sdata_i,
  output logic sdata_o,
  output logic sdata_oe_o
);
  logic [2:0] sync_q;
  logic [7:0] ptr, wr_data, rd_data;
  logic       wr_en, sdo, drive, od_mode;

  tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sel_ni, sdata_i}),
    .q_o   (sync_q)
  );

  tw_frame i_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sync_q[2]),
    .sel_ni   (sync_q[1]),
    .sd_i     (sync_q[0]),
    .rd_data_i(rd_data),
    .ptr_o    (ptr),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data),
    .sdo_o    (sdo),
    .drive_o  (drive)
  );

  tw_regfile #(.NUM_REGS(NUM_REGS)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (ptr),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .od_mode_o(od_mode)
  );

  assign sdata_o    = od_mode ? 1'b0 : sdo;
  assign sdata_oe_o = drive & (~od_mode | ~sdo);

  // R9
  od_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_mode && sdata_oe_o) |-> !sdata_o);
endmodule

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
  localparam int NR = 16;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sel_n = 1'b1, sd = 1'b0;
  logic sdata_o, sdata_oe_o;
  int checks = 0, errors = 0;
  int mregs [256];
  int mptr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tw_reg_slave #(.NUM_REGS(NR), .SYNC_STAGES(2)) i_tw_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sel_ni(sel_n),
    .sdata_i(sd), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int m_rd(input int a);
    return (a < NR) ? mregs[a] : 0;
  endfunction

  function automatic bit m_od();
    return (NR > 2) && mregs[2][4];
  endfunction

  task automatic idle_toggles(input int n);
    for (int k = 0; k < n; k++) begin
      sclk = 1'b0; wt(H); sclk = 1'b1; wt(H);
    end
  endtask

  task automatic frame(input logic [7:0] ins, input logic [7:0] dat, input int extra);
    logic [15:0] w;
    logic [7:0] exp_b;
    bit is_rd;
    w = {ins, dat};
    is_rd = (ins == 8'h80) || (ins == 8'hA0);
    exp_b = 8'(m_rd(mptr));
    sel_n = 1'b0; wt(H);
    for (int i = 0; i < 16 + extra; i++) begin
      sclk = 1'b0;
      sd = (i < 16) ? w[15-i] : ~w[i%16];
      wt(H);
      if (i >= 8 && i < 16 && is_rd) begin
        if (m_od()) begin
          // R9 open-drain: line pulled up unless enabled with 0
          chk((sdata_oe_o ? sdata_o : 1'b1) == exp_b[15-i], "R9", int'(sdata_oe_o), int'(exp_b[15-i]));
          chk(!(sdata_oe_o && sdata_o), "R9", int'(sdata_o), 0);
        end else begin
          // R5 push-pull read bit, MSB first
          chk(sdata_oe_o && sdata_o == exp_b[15-i], "R5", {sdata_oe_o, sdata_o}, {1'b1, exp_b[15-i]});
        end
      end else if (i < 16) begin
        // R8 no drive outside a read's second byte
        chk(!sdata_oe_o, "R8", int'(sdata_oe_o), 0);
      end
      sclk = 1'b1; wt(H);
    end
    sel_n = 1'b1; wt(4 + 2);
    // R1 line released after select rises
    chk(!sdata_oe_o, "R1", int'(sdata_oe_o), 0);
    case (ins)
      8'h00: mptr = int'(dat);
      8'h40: if (mptr < NR) mregs[mptr] = int'(dat);
      8'h60: begin if (mptr < NR) mregs[mptr] = int'(dat); mptr = (mptr + 1) % 256; end
      8'hA0: mptr = (mptr + 1) % 256;
      default: ;
    endcase
  endtask

  task automatic read_expect(input logic [7:0] a, input int exp, input string req);
    logic [7:0] got;
    frame(8'h00, a, 0);
    // gather read via line: reconstruct after frame by pre-check model value
    got = 8'(m_rd(mptr));
    chk(int'(got) == exp, req, int'(got), exp);
    frame(8'h80, 8'h00, 0);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mregs[k] = 0;
    wt(3);
    // R12 reset state
    chk(!sdata_oe_o, "R12", int'(sdata_oe_o), 0);
    rst_n = 1'b1; wt(4);
    chk(!sdata_oe_o, "R12", int'(sdata_oe_o), 0);
    frame(8'h80, 8'h00, 0);               // R12 register 0 reads 0x00

    // R2 R3 set pointer, write, read back
    frame(8'h00, 8'h05, 0);
    frame(8'h40, 8'hA5, 0);
    frame(8'h80, 8'h00, 0);
    read_expect(8'h05, 'hA5, "R3");

    // R4 write with increment, R6 read with increment
    frame(8'h00, 8'h03, 0);
    frame(8'h60, 8'h11, 0);
    frame(8'h60, 8'h3C, 0);
    chk(mptr == 5, "R4", mptr, 5);
    frame(8'h00, 8'h03, 0);
    frame(8'hA0, 8'h00, 0);
    frame(8'hA0, 8'h00, 0);
    frame(8'h80, 8'h00, 0);               // R6 pointer at 5 -> 0xA5

    // R8 undefined instruction
    frame(8'h00, 8'h07, 0);
    frame(8'h41, 8'hFF, 0);
    frame(8'hC0, 8'hEE, 0);
    frame(8'h80, 8'h00, 0);               // R8 register 7 still 0
    frame(8'h40, 8'h96, 0);
    frame(8'h20, 8'h00, 0);
    frame(8'h80, 8'h00, 0);               // R8 pointer not moved

    // R10 unbacked address
    frame(8'h00, 8'h40, 0);
    frame(8'h40, 8'h77, 0);
    frame(8'h80, 8'h00, 0);

    // R7 wrap
    frame(8'h00, 8'hFF, 0);
    frame(8'hA0, 8'h00, 0);
    chk(mptr == 0, "R7", mptr, 0);
    frame(8'h80, 8'h00, 0);
    frame(8'h00, 8'hFF, 0);
    frame(8'h60, 8'h12, 0);
    frame(8'h40, 8'h5A, 0);
    frame(8'h80, 8'h00, 0);               // R7 register 0 now 0x5A

    // R11 continuous clock and surplus bits
    idle_toggles(5);
    frame(8'h00, 8'h09, 0);
    idle_toggles(3);
    frame(8'h40, 8'hC3, 8);
    idle_toggles(2);
    frame(8'h80, 8'h00, 4);

    // R9 open-drain mode
    frame(8'h00, 8'h02, 0);
    frame(8'h40, 8'h10, 0);
    frame(8'h00, 8'h05, 0);
    frame(8'h80, 8'h00, 0);
    frame(8'h00, 8'h09, 0);
    frame(8'h80, 8'h00, 0);
    frame(8'h00, 8'h02, 0);
    frame(8'h40, 8'h00, 0);
    frame(8'h00, 8'h05, 0);
    frame(8'h80, 8'h00, 0);

    // R1 aborted pair does nothing
    sel_n = 1'b0; wt(H);
    for (int i = 0; i < 12; i++) begin
      sclk = 1'b0; sd = (i == 1); wt(H); sclk = 1'b1; wt(H);
    end
    sel_n = 1'b1; wt(6);
    chk(!sdata_oe_o, "R1", int'(sdata_oe_o), 0);
    frame(8'h80, 8'h00, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule